// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked request stream inside the chip and an external asynchronous static RAM. The RAM holds 16-bit words at 18-bit addresses. Each request carries an address, write data, a two-bit byte-enable and a read/write flag. The controller turns each request into a correctly ordered strobe sequence on the memory pins. The memory is selected only while its active-low select is low and its active-high select is high. Each byte lane has its own active-low strobe. The controller returns to standby after every access.

The request side follows valid/ready rules. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, a requester holds its request and the controller ignores it. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_rdata` is valid only in that cycle for a read. The length of the read window and of the write-enable pulse is set by `WAIT_CYCLES`. Choose it as the memory's cycle time divided by the clock period, rounded up (55 ns at 8 ns gives 7).

The data bus is split into `sram_dq_out`, `sram_dq_in` and the driver enable `sram_dq_oe`, so a pad ring can build the tristate buffer. The controller drives the bus only while the memory's output-enable is inactive.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever idle, the memory pins are in standby: `sram_cs1_n`=1, `sram_cs2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_ub_n`=1, `sram_lb_n`=1 and `sram_dq_oe`=0. In this state `req_ready`=1.
- R2: `req_ready` is low from the accepting edge until the controller is idle again. A request presented while `req_ready` is low is not taken and has no effect on memory. `rsp_valid` lasts exactly one cycle.
- R3: During an access the chip is selected (`sram_cs1_n`=0, `sram_cs2`=1). `req_be[0]`=1 pulls `sram_lb_n` low for data bits 7:0, and `req_be[1]`=1 pulls `sram_ub_n` low for bits 15:8. Only the enabled lanes are written.
- R4: A write spends one setup cycle selected, with `sram_we_n` high and the driver off. It then holds `sram_we_n` low with the driver on for exactly `WAIT_CYCLES` cycles. It then spends one cycle with `sram_we_n` high and the driver still on, and only then releases the bus.
- R5: A read keeps the driver off and holds `sram_oe_n` low for exactly `WAIT_CYCLES` cycles. It samples `sram_dq_in` in the last of those cycles and presents the sample on `rsp_rdata` with `rsp_valid`.
- R6: In read data, a lane whose byte-enable bit was 0 returns 8'h00.
- R7: A request with `req_be`=2'b00 completes with `rsp_valid` one cycle after acceptance. The chip is never selected during it.
- R8: `sram_dq_oe` is never high while `sram_oe_n` is low, and `sram_we_n` and `sram_oe_n` are never both low.
- R9: `sram_addr` stays constant while the chip is selected, and the write data stays on the bus when `sram_we_n` rises.
- R10: Counted from the accepting edge, `rsp_valid` appears after `WAIT_CYCLES`+3 cycles for a write and after `WAIT_CYCLES`+1 cycles for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data with disabled lanes zeroed |
| sram_addr | output | 18 | Memory address |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_ub_n | output | 1 | Active-low high-byte strobe |
| sram_lb_n | output | 1 | Active-low low-byte strobe |
| sram_dq_out | output | 16 | Data driven toward memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 16 | Data returned from the bus |

## Verification
The bench uses a behavioural memory model that fills disabled read lanes with nonzero filler. A controller that does not zero those lanes returns the filler, and one that swaps the strobes corrupts the byte that was not addressed. The model also watches the write-enable and output-enable pulse widths and the setup cycle. A controller that drops the setup or hold cycle, or uses a wait count off by one, shows up as a wrong pulse length or a wrong latency. Bus contention is flagged whenever the model and the controller drive together. Two directed cases cover the rest. A request held during a busy access must not be executed. A request with no byte enables must finish without selecting the chip.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RWAIT  = 3'd4,
    ST_DONE   = 3'd5
  } ctl_state_e;
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int WAIT_CYCLES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(WAIT_CYCLES) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign last = run && (cnt == CW'(WAIT_CYCLES - 1));

  // R4
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(WAIT_CYCLES)));
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int LANES = 2
) (
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   lane_en,
  output logic [LANES*8-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*8 +: 8] = lane_en[g] ? din[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_write,
  input  logic       start_none,
  input  logic       wait_last,
  output ctl_state_e state
);
  ctl_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) begin
        if (start_none)       nxt = ST_DONE;
        else if (start_write) nxt = ST_WSETUP;
        else                  nxt = ST_RWAIT;
      end
      ST_WSETUP: nxt = ST_WPULSE;
      ST_WPULSE: if (wait_last) nxt = ST_WHOLD;
      ST_WHOLD:  nxt = ST_DONE;
      ST_RWAIT:  if (wait_last) nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R7
  none_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && start_none) |=> (state == ST_DONE));
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int WAIT_CYCLES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int LANES = DATA_W / 8;

  ctl_state_e        state;
  logic              accept, wait_run, wait_last, active;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
  logic [LANES-1:0]  be_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  sram_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_write(req_write),
    .start_none(req_be == 2'b00), .wait_last(wait_last), .state(state)
  );

  assign wait_run = (state == ST_WPULSE) || (state == ST_RWAIT);

  sram_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .last(wait_last)
  );

  sram_lane_mask #(.LANES(LANES)) u_mask (
    .din(sram_dq_in), .lane_en(be_q), .dout(rd_masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                rdata_q <= '0;
    else if (state == ST_RWAIT && wait_last)   rdata_q <= rd_masked;
  end

  assign active      = (state != ST_IDLE) && (state != ST_DONE);
  assign sram_addr   = addr_q;
  assign sram_cs1_n  = ~active;
  assign sram_cs2    = active;
  assign sram_lb_n   = ~(active & be_q[0]);
  assign sram_ub_n   = ~(active & be_q[LANES-1]);
  assign sram_we_n   = ~(state == ST_WPULSE);
  assign sram_oe_n   = ~(state == ST_RWAIT);
  assign sram_dq_oe  = (state == ST_WPULSE) || (state == ST_WHOLD);
  assign sram_dq_out = wdata_q;
  assign rsp_valid   = (state == ST_DONE);
  assign rsp_rdata   = rdata_q;

  // R8
  excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
  // R8
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n &&
                   sram_ub_n && sram_lb_n && !sram_dq_oe));
  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs1_n && !$past(sram_cs1_n)) |-> $stable(sram_addr));
  // R9
  we_rise_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_dq_oe && !sram_cs1_n));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int W = 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n;
  logic sram_ub_n, sram_lb_n, sram_dq_oe;
  logic [15:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [17:0] sram_addr;

  int checks = 0, errors = 0;
  logic [15:0] mem    [logic [17:0]];
  logic [15:0] shadow [logic [17:0]];

  always #4 clk = ~clk;

  sram_lane_ctrl #(.WAIT_CYCLES(W)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n),
    .sram_lb_n(sram_lb_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  function automatic logic [15:0] mem_word(logic [17:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] exp_word(logic [17:0] a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] lane_merge(logic [15:0] old, logic [15:0] nw, logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] lane_zero(logic [15:0] w, logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory model
  wire sel    = !sram_cs1_n && sram_cs2;
  wire mdrive = sel && !sram_oe_n && sram_we_n && (!sram_ub_n || !sram_lb_n);
  always_comb begin
    logic [15:0] w;
    w = mem_word(sram_addr);
    if (mdrive)          sram_dq_in = {!sram_ub_n ? w[15:8] : 8'hA5, !sram_lb_n ? w[7:0] : 8'h5A};
    else if (sram_dq_oe) sram_dq_in = sram_dq_out;
    else                 sram_dq_in = 16'hFFFF;
  end

  // pin monitors, sampled at the falling edge
  logic prev_we = 1, prev_oe = 1, prev_sel = 0, prev_we_setup_ok = 0;
  int we_low = 0, oe_low = 0, clash = 0;
  bit bus_touched = 0;
  always @(negedge clk) if (rst_n) begin
    if (sel) bus_touched = 1;
    if (mdrive && sram_dq_oe) clash++;
    if (!sram_we_n) we_low++;
    if (!sram_oe_n) oe_low++;
    if (prev_we && !sram_we_n)
      chk(prev_we_setup_ok, "R4 setup cycle before WE low", {31'b0, prev_we_setup_ok}, 1);
    if (!prev_we && sram_we_n) begin
      chk(we_low == W, "R4 WE low width", we_low, W);
      chk(sram_dq_oe && sel, "R9 data held at WE rise", {30'b0, sram_dq_oe, sel}, 3);
      if (sel) mem[sram_addr] = lane_merge(mem_word(sram_addr), sram_dq_out, {!sram_ub_n, !sram_lb_n});
      we_low = 0;
    end
    if (!prev_oe && sram_oe_n) begin
      chk(oe_low == W, "R5 OE low width", oe_low, W);
      oe_low = 0;
    end
    prev_we_setup_ok = sel && sram_we_n && !sram_dq_oe;
    prev_we = sram_we_n;
    prev_oe = sram_oe_n;
    prev_sel = sel;
  end

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd, output int lat);
    @(negedge clk);
    chk(req_ready, "R2 ready when idle", {31'b0, req_ready}, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    bus_touched = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] rd; int lat;
    access(1, a, d, be, rd, lat);
    if (be == 2'b00) begin
      chk(lat == 1, "R7 empty write latency", lat, 1);
      chk(!bus_touched, "R7 chip not selected", {31'b0, bus_touched}, 0);
    end else begin
      chk(lat == W + 3, "R10 write latency", lat, W + 3);
      shadow[a] = lane_merge(exp_word(a), d, be);
    end
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be);
    logic [15:0] rd, ex; int lat;
    access(0, a, 16'h0, be, rd, lat);
    if (be == 2'b00) begin
      chk(lat == 1, "R7 empty read latency", lat, 1);
      chk(!bus_touched, "R7 chip not selected", {31'b0, bus_touched}, 0);
    end else begin
      ex = lane_zero(exp_word(a), be);
      chk(lat == W + 1, "R10 read latency", lat, W + 1);
      chk(rd == ex, "R5 R6 R3 read data", rd, ex);
    end
  endtask

  task automatic finish_run();
    chk(clash == 0, "R8 bus contention cycles", clash, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe} == 7'b1011110,
        "R1 standby in reset",
        {25'b0, sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 7'b1011110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after reset", {30'b0, req_ready, rsp_valid}, 2);

    // directed lane cases, R3
    do_write(18'h00000, 16'h1234, 2'b11);
    do_write(18'h00000, 16'hAB00, 2'b10);
    do_read (18'h00000, 2'b11);
    do_write(18'h3FFFF, 16'hCDEF, 2'b01);
    do_read (18'h3FFFF, 2'b11);
    do_read (18'h3FFFF, 2'b01);
    do_read (18'h00000, 2'b10);
    do_write(18'h00000, 16'hFFFF, 2'b00);
    do_read (18'h00000, 2'b00);
    do_read (18'h00000, 2'b11);

    // R2: a request held while busy must not be taken
    begin
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 18'h00011; req_wdata = 16'h5555; req_be = 2'b11;
      @(posedge clk);
      @(negedge clk);
      req_addr = 18'h00022; req_wdata = 16'hBEEF;
      chk(!req_ready, "R2 not ready while busy", {31'b0, req_ready}, 0);
      while (!rsp_valid) @(negedge clk);
      req_valid = 0;
      shadow[18'h00011] = 16'h5555;
      do_read(18'h00022, 2'b11);
      do_read(18'h00011, 2'b11);
    end

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [17:0] a;
      a = {2'($urandom_range(0, 3)), 12'h0, 4'($urandom_range(0, 15))};
      if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom), 2'($urandom_range(0, 3)));
      else                           do_read(a, 2'($urandom_range(0, 3)));
    end
    finish_run();
  end
endmodule